// File: doc/BRIEF.md
# Two-Level 32-Bit Page Table Walker

This block translates one 32-bit virtual address at a time under classic two-level 32-bit paging. A walk starts with a single-cycle `start` pulse that captures the address, the access kind (read or write), the privilege (user or supervisor), the page-directory root, the write-protect and large-page enables and the address-line-20 mask. With paging off the address passes through unchanged apart from the mask. With paging on the block fetches the directory entry and, when needed, the table entry over a 32-bit memory port. It then checks the permissions and writes any accessed and dirty bits back in place.

Each walk ends with a one-cycle `done` pulse. The pulse carries either a physical byte address and a protection set, or a page fault with a three-bit error code and the faulting virtual address. The memory port has one outstanding access at a time and uses a valid/ready handshake. The read data counts as valid in the cycle where `mem_valid` and `mem_ready` are both high.

Entry bit positions used throughout: present bit 0, writable bit 1, user bit 2, accessed bit 5, dirty bit 6, large-page bit 7. The protection output is `{exec, write, read}` (bit 2 to bit 0). The error code is `{user, write, violation}` (bit 2 to bit 0).

Top module: `pt_walker`

## Requirements
- R1: After reset `done`, `fault`, `mem_valid`, `err_code`, `prot`, `phys_addr` and `fault_addr` are all 0.
- R2: With `paging_on` low, a start produces `done` in the first cycle after the start edge with no memory access, `phys_addr = vaddr & a20_mask`, `prot = 3'b111` and `fault = 0`.
- R3: The first read of a walk targets `((root_base & ~0xFFF) + vaddr[31:22]*4) & a20_mask`.
- R4: A table read targets `((dir_entry & ~0xFFF) + vaddr[21:12]*4) & a20_mask`, and the translation is `{tbl_entry[31:12], vaddr[11:0]} & a20_mask`.
- R5: A directory entry with bit 7 set while `pse_on` is high maps a 4 MB page. The walk then makes no table read and returns `{dir_entry[31:22], vaddr[21:0]} & a20_mask`. With `pse_on` low, bit 7 has no effect and the walk continues to the table.
- R6: An entry with bit 0 clear ends the walk with `fault = 1` and error bit 0 = 0. In every fault, error bit 1 equals the write flag, error bit 2 equals the user flag, and `fault_addr` equals the virtual address. `fault_addr` keeps its value across successful walks.
- R7: For 4 KB pages the user and writable rights are the AND of the directory and table entries. A user access faults without the user right, and a user write faults without the writable right. A supervisor write faults only when `wp_on` is high and the writable right is missing. These faults set error bit 0.
- R8: A final or directory entry whose bit 5 is clear is written back to the address it was read from, with bit 5 set. An entry whose bit 5 is already set (and needs no dirty update) is not written.
- R9: A write access that passes the checks sets bit 6 in the final entry in that same write-back. A directory entry that points to a table never has bit 6 set by the walker.
- R10: On success, read and exec are granted. Write is granted only if the final entry is dirty after the walk and the rights allow it: for a user access when the writable right is present, and for a supervisor access when the writable right is present or `wp_on` is low.
- R11: `mem_valid` with `mem_we`, `mem_addr` and `mem_wdata` stays stable until `mem_ready`. `done` lasts exactly one cycle. A `start` during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a write |
| is_user | input | 1 | Access is at user privilege |
| paging_on | input | 1 | Paging enabled |
| root_base | input | 32 | Page-directory root (low 12 bits ignored) |
| wp_on | input | 1 | Supervisor writes honour the writable right |
| pse_on | input | 1 | Large 4 MB pages enabled |
| a20_mask | input | 32 | Mask applied to every physical address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted / read data valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | One-cycle walk-complete pulse |
| fault | output | 1 | Walk ended in a page fault |
| err_code | output | 3 | Fault code {user, write, violation} |
| fault_addr | output | 32 | Virtual address of the last fault |
| phys_addr | output | 32 | Translated physical byte address |
| prot | output | 3 | Granted rights {exec, write, read} |

## Verification
A corrupted walk state or captured entry shows up at the memory port within one access. The wrong address is issued, an access is missing or extra, or a write-back carries the wrong accessed or dirty bits. A wrong rights combination or a lost dirty update appears in the same `done` pulse as a flipped fault flag, error bit or write grant. A lost request capture shows as a wrong `fault_addr` or `phys_addr` in that pulse. The directed tests compare each walk's full access log and its results against values worked out from the entry bits.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int PW_AW    = 32;
    localparam int PW_IDX_W = 10;
    localparam int PW_OFS_W = 12;
    localparam int PW_BIG_W = PW_OFS_W + PW_IDX_W;

    localparam int E_PRES  = 0;
    localparam int E_WR    = 1;
    localparam int E_USR   = 2;
    localparam int E_ACC   = 5;
    localparam int E_DIRTY = 6;
    localparam int E_BIG   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_CHK,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_CHK,
        ST_TBL_WB
    } walk_st_e;

    typedef struct packed {
        logic [PW_AW-1:0] va;
        logic [PW_AW-1:0] root;
        logic [PW_AW-1:0] a20;
        logic             wr;
        logic             usr;
        logic             wp;
        logic             pse;
    } walk_req_t;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } prot_t;

    function automatic logic [2:0] mk_err(input logic viol, input logic wr, input logic usr);
        return {usr, wr, viol};
    endfunction

    function automatic logic [PW_AW-1:0] bit_of(input int pos);
        return PW_AW'(1) << pos;
    endfunction
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int AW    = 32,
    parameter int IDX_W = 10,
    parameter int OFS_W = 12
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    input  logic [AW-1:0]    a20,
    output logic [AW-1:0]    addr
);
    localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << OFS_W) - 64'd1);

    always_comb begin
        addr = ((base & ~LOW_MASK) + AW'({idx, 2'b00})) & a20;
    end
endmodule

// File: rtl/pw_access_check.sv
module pw_access_check (
    input  logic ent_usr,
    input  logic ent_wr,
    input  logic ent_dirty,
    input  logic is_user,
    input  logic is_write,
    input  logic wp,
    output logic deny,
    output logic wr_grant
);
    logic may_write;

    always_comb begin
        may_write = is_user ? ent_wr : (ent_wr | ~wp);
        deny      = (is_user & ~ent_usr) | (is_write & ~may_write);
        // dirty after the walk: already dirty or set by this write
        wr_grant  = (ent_dirty | is_write) & may_write;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] vaddr,
    input  logic        is_write,
    input  logic        is_user,
    input  logic        paging_on,
    input  logic [31:0] root_base,
    input  logic        wp_on,
    input  logic        pse_on,
    input  logic [31:0] a20_mask,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        fault,
    output logic [2:0]  err_code,
    output logic [31:0] fault_addr,
    output logic [31:0] phys_addr,
    output logic [2:0]  prot
);
    walk_st_e         st;
    walk_req_t        req_q;
    logic [PW_AW-1:0] dir_q, tbl_q, wb_q;
    logic             big_q;
    logic             done_q, fault_q;
    logic [2:0]       err_q;
    logic [PW_AW-1:0] cr2_q, pa_q;
    prot_t            prot_q;

    logic [PW_AW-1:0] dir_addr, tbl_addr;
    logic             big_deny, big_grant, sml_deny, sml_grant;
    logic             big_page, big_need_wb, tbl_need_wb;
    logic [PW_AW-1:0] big_pa, sml_pa;

    pw_addr_gen #(.AW(PW_AW), .IDX_W(PW_IDX_W), .OFS_W(PW_OFS_W)) u_dir_addr (
        .base(req_q.root), .idx(req_q.va[PW_AW-1 -: PW_IDX_W]), .a20(req_q.a20), .addr(dir_addr)
    );

    pw_addr_gen #(.AW(PW_AW), .IDX_W(PW_IDX_W), .OFS_W(PW_OFS_W)) u_tbl_addr (
        .base(dir_q), .idx(req_q.va[PW_BIG_W-1 -: PW_IDX_W]), .a20(req_q.a20), .addr(tbl_addr)
    );

    pw_access_check u_big_chk (
        .ent_usr(dir_q[E_USR]), .ent_wr(dir_q[E_WR]), .ent_dirty(dir_q[E_DIRTY]),
        .is_user(req_q.usr), .is_write(req_q.wr), .wp(req_q.wp),
        .deny(big_deny), .wr_grant(big_grant)
    );

    pw_access_check u_sml_chk (
        .ent_usr(dir_q[E_USR] & tbl_q[E_USR]), .ent_wr(dir_q[E_WR] & tbl_q[E_WR]),
        .ent_dirty(tbl_q[E_DIRTY]),
        .is_user(req_q.usr), .is_write(req_q.wr), .wp(req_q.wp),
        .deny(sml_deny), .wr_grant(sml_grant)
    );

    always_comb begin
        big_page    = dir_q[E_BIG] & req_q.pse;
        big_need_wb = ~dir_q[E_ACC] | (req_q.wr & ~dir_q[E_DIRTY]);
        tbl_need_wb = ~tbl_q[E_ACC] | (req_q.wr & ~tbl_q[E_DIRTY]);
        big_pa      = {dir_q[PW_AW-1:PW_BIG_W], req_q.va[PW_BIG_W-1:0]} & req_q.a20;
        sml_pa      = {tbl_q[PW_AW-1:PW_OFS_W], req_q.va[PW_OFS_W-1:0]} & req_q.a20;
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = wb_q;
        unique case (st)
            ST_DIR_RD:  mem_valid = 1'b1;
            ST_DIR_WB:  begin mem_valid = 1'b1; mem_we = 1'b1; end
            ST_TBL_RD:  begin mem_valid = 1'b1; mem_addr = tbl_addr; end
            ST_TBL_WB:  begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr; end
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req_q   <= '0;
            dir_q   <= '0;
            tbl_q   <= '0;
            wb_q    <= '0;
            big_q   <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            err_q   <= '0;
            cr2_q   <= '0;
            pa_q    <= '0;
            prot_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start && !done_q) begin
                        req_q <= '{va: vaddr, root: root_base, a20: a20_mask,
                                   wr: is_write, usr: is_user, wp: wp_on, pse: pse_on};
                        if (!paging_on) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= vaddr & a20_mask;
                            prot_q  <= '{x: 1'b1, w: 1'b1, r: 1'b1};
                        end else begin
                            st <= ST_DIR_RD;
                        end
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ready) begin
                        dir_q <= mem_rdata;
                        st    <= ST_DIR_CHK;
                    end
                end
                ST_DIR_CHK: begin
                    if (!dir_q[E_PRES]) begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b1;
                        err_q   <= mk_err(1'b0, req_q.wr, req_q.usr);
                        cr2_q   <= req_q.va;
                        st      <= ST_IDLE;
                    end else if (big_page) begin
                        if (big_deny) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            err_q   <= mk_err(1'b1, req_q.wr, req_q.usr);
                            cr2_q   <= req_q.va;
                            st      <= ST_IDLE;
                        end else if (big_need_wb) begin
                            wb_q  <= dir_q | bit_of(E_ACC) | (req_q.wr ? bit_of(E_DIRTY) : '0);
                            big_q <= 1'b1;
                            st    <= ST_DIR_WB;
                        end else begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= big_pa;
                            prot_q  <= '{x: 1'b1, w: big_grant, r: 1'b1};
                            st      <= ST_IDLE;
                        end
                    end else if (!dir_q[E_ACC]) begin
                        wb_q  <= dir_q | bit_of(E_ACC);
                        big_q <= 1'b0;
                        st    <= ST_DIR_WB;
                    end else begin
                        st <= ST_TBL_RD;
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ready) begin
                        if (big_q) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= big_pa;
                            prot_q  <= '{x: 1'b1, w: big_grant, r: 1'b1};
                            st      <= ST_IDLE;
                        end else begin
                            st <= ST_TBL_RD;
                        end
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ready) begin
                        tbl_q <= mem_rdata;
                        st    <= ST_TBL_CHK;
                    end
                end
                ST_TBL_CHK: begin
                    if (!tbl_q[E_PRES] || sml_deny) begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b1;
                        err_q   <= mk_err(tbl_q[E_PRES], req_q.wr, req_q.usr);
                        cr2_q   <= req_q.va;
                        st      <= ST_IDLE;
                    end else if (tbl_need_wb) begin
                        wb_q <= tbl_q | bit_of(E_ACC) | (req_q.wr ? bit_of(E_DIRTY) : '0);
                        st   <= ST_TBL_WB;
                    end else begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b0;
                        err_q   <= '0;
                        pa_q    <= sml_pa;
                        prot_q  <= '{x: 1'b1, w: sml_grant, r: 1'b1};
                        st      <= ST_IDLE;
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ready) begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b0;
                        err_q   <= '0;
                        pa_q    <= sml_pa;
                        prot_q  <= '{x: 1'b1, w: sml_grant, r: 1'b1};
                        st      <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign fault      = fault_q;
    assign err_code   = err_q;
    assign fault_addr = cr2_q;
    assign phys_addr  = pa_q;
    assign prot       = prot_q;

    // R11: request held steady until accepted
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: every write-back carries the accessed bit
    a_r8_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> mem_wdata[E_ACC]);

    // R6: fault reports the captured request
    a_r6_fault_fields: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> fault_addr == req_q.va && err_code[1] == req_q.wr && err_code[2] == req_q.usr);

    // R10: a successful walk always grants read and exec
    a_r10_read_exec: assert property (@(posedge clk) disable iff (rst)
        done && !fault |-> prot[0] && prot[2]);

    // R9: a table-pointing directory entry is never written with dirty set
    a_r9_no_dir_dirty: assert property (@(posedge clk) disable iff (rst)
        st == ST_DIR_WB && !big_q |-> !mem_wdata[E_DIRTY] || dir_q[E_DIRTY]);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic        is_write = 1'b0, is_user = 1'b0, paging_on = 1'b0;
    logic [31:0] root_base = '0;
    logic        wp_on = 1'b0, pse_on = 1'b0;
    logic [31:0] a20_mask = 32'hFFFF_FFFF;
    logic        mem_valid, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        done, fault;
    logic [2:0]  err_code, prot;
    logic [31:0] fault_addr, phys_addr;

    pt_walker dut (
        .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .is_write(is_write),
        .is_user(is_user), .paging_on(paging_on), .root_base(root_base), .wp_on(wp_on),
        .pse_on(pse_on), .a20_mask(a20_mask), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .err_code(err_code), .fault_addr(fault_addr),
        .phys_addr(phys_addr), .prot(prot)
    );

    always #2.5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    logic [31:0] mem [int unsigned];
    int          mem_lat = 0, wait_cnt = 0;
    int          nacc = 0;
    logic [31:0] acc_addr [8];
    logic [31:0] acc_data [8];
    logic        acc_we   [8];
    int          r_cyc;

    localparam logic [31:0] ROOT = 32'h0001_0000;
    localparam logic [31:0] VA   = 32'h0040_3ABC;
    localparam logic [31:0] DIRA = 32'h0001_0004;
    localparam logic [31:0] TBLA = 32'h0002_000C;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (wait_cnt < mem_lat) wait_cnt++;
            else begin
                wait_cnt  = 0;
                mem_ready = 1'b1;
                mem_rdata = rd(mem_addr);
                if (mem_we) mem[mem_addr] = mem_wdata;
                if (nacc < 8) begin
                    acc_addr[nacc] = mem_addr;
                    acc_data[nacc] = mem_we ? mem_wdata : mem_rdata;
                    acc_we[nacc]   = mem_we;
                end
                nacc++;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input bit pg,
                        input bit pse, input bit wp, input logic [31:0] a20);
        @(negedge clk);
        nacc = 0;
        vaddr = va; is_write = wr; is_user = usr; paging_on = pg;
        pse_on = pse; wp_on = wp; a20_mask = a20; root_base = ROOT;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cyc = 1;
        while (!done && r_cyc < 200) begin
            @(negedge clk);
            r_cyc++;
        end
        if (r_cyc >= 200) chk(1'b0, "walk timeout", 32'(r_cyc), 32'd0);
    endtask

    task automatic chk_acc(input int i, input bit we, input logic [31:0] a, input logic [31:0] d, input string tag);
        chk(acc_we[i] == we && acc_addr[i] == a, {tag, " access addr/kind"}, acc_addr[i], a);
        chk(acc_data[i] == d, {tag, " access data"}, acc_data[i], d);
    endtask

    task automatic t_reset;
        chk(!done && !fault && !mem_valid, "R1 reset handshake/flags", {29'd0, done, fault, mem_valid}, 32'd0);
        chk(err_code == 0 && prot == 0, "R1 reset codes", {26'd0, err_code, prot}, 32'd0);
        chk(phys_addr == 0 && fault_addr == 0, "R1 reset addresses", phys_addr | fault_addr, 32'd0);
    endtask

    task automatic t_pg_off;
        walk(32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFEF_FFFF);
        chk(r_cyc == 1, "R2 done latency", 32'(r_cyc), 32'd1);
        chk(nacc == 0, "R2 no memory access", 32'(nacc), 32'd0);
        chk(phys_addr == 32'h1224_5678, "R2 passthrough with a20", phys_addr, 32'h1224_5678);
        chk(prot == 3'b111 && !fault, "R2 full rights", {28'd0, fault, prot}, 32'h7);
    endtask

    task automatic t_small_read;
        mem.delete();
        mem[DIRA] = 32'h0002_0027;
        mem[TBLA] = 32'h0055_5067;
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(nacc == 2, "R8 no write-back when accessed", 32'(nacc), 32'd2);
        chk_acc(0, 1'b0, DIRA, 32'h0002_0027, "R3");
        chk_acc(1, 1'b0, TBLA, 32'h0055_5067, "R4");
        chk(!fault && phys_addr == 32'h0055_5ABC, "R4 4K translation", phys_addr, 32'h0055_5ABC);
        chk(prot == 3'b111, "R10 dirty user writable", {29'd0, prot}, 32'h7);
    endtask

    task automatic t_accessed_wb;
        mem.delete();
        mem[DIRA] = 32'h0002_0007;
        mem[TBLA] = 32'h0055_5007;
        walk(VA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(nacc == 4, "R8 access count", 32'(nacc), 32'd4);
        chk_acc(1, 1'b1, DIRA, 32'h0002_0027, "R8 dir");
        chk_acc(3, 1'b1, TBLA, 32'h0055_5027, "R8 tbl");
        chk(prot == 3'b101, "R10 clean entry no write", {29'd0, prot}, 32'h5);
    endtask

    task automatic t_dirty;
        mem.delete();
        mem[DIRA] = 32'h0002_0027;
        mem[TBLA] = 32'h0055_5023;
        walk(VA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
        chk(nacc == 3, "R9 only final entry written", 32'(nacc), 32'd3);
        chk_acc(2, 1'b1, TBLA, 32'h0055_5063, "R9");
        chk(!fault && prot == 3'b111, "R10 write granted after dirty", {28'd0, fault, prot}, 32'h7);
        chk(rd(DIRA) == 32'h0002_0027, "R9 dir untouched", rd(DIRA), 32'h0002_0027);
    endtask

    task automatic t_big;
        mem.delete();
        mem[DIRA] = 32'h0C00_0087;
        mem[32'h0C00_000C] = 32'h0077_7067;
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
        chk(nacc == 2, "R5 large page one read plus wb", 32'(nacc), 32'd2);
        chk_acc(1, 1'b1, DIRA, 32'h0C00_00A7, "R5 R8");
        chk(phys_addr == 32'h0C00_3ABC && prot == 3'b101, "R5 large translation", phys_addr, 32'h0C00_3ABC);
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(nacc == 2 && acc_addr[1] == 32'h0C00_000C, "R5 PS ignored without pse", acc_addr[1], 32'h0C00_000C);
        chk(phys_addr == 32'h0077_7ABC, "R5 table used", phys_addr, 32'h0077_7ABC);
        walk(32'h0050_0ABC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFEF_FFFF);
        chk(phys_addr == 32'h0C00_0ABC, "R5 a20 on large page", phys_addr, 32'h0C00_0ABC);
    endtask

    task automatic t_not_present;
        mem.delete();
        walk(VA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(fault && err_code == 3'b110, "R6 dir not present", {28'd0, fault, err_code}, 32'hE);
        chk(fault_addr == VA && nacc == 1, "R6 fault address", fault_addr, VA);
        mem[DIRA] = 32'h0002_0027;
        walk(VA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(fault && err_code == 3'b000, "R6 tbl not present", {28'd0, fault, err_code}, 32'h8);
        mem[TBLA] = 32'h0055_5067;
        walk(VA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        walk(32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(fault_addr == 32'h0000_0000 && fault, "R6 second fault address", fault_addr, 32'h0);
        walk(VA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(!fault && fault_addr == 32'h0, "R6 fault address held", fault_addr, 32'h0);
    endtask

    task automatic t_perm;
        mem.delete();
        mem[DIRA] = 32'h0002_0027;
        mem[TBLA] = 32'h0055_5063;
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(fault && err_code == 3'b101, "R7 user without user bit", {28'd0, fault, err_code}, 32'hD);
        mem[DIRA] = 32'h0002_0025;
        mem[TBLA] = 32'h0055_5067;
        walk(VA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(fault && err_code == 3'b111, "R7 user write dir read-only", {28'd0, fault, err_code}, 32'hF);
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(!fault && prot == 3'b101, "R7 R10 user read ok, no write", {28'd0, fault, prot}, 32'h5);
        walk(VA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk(!fault && prot == 3'b111, "R7 sup write without wp", {28'd0, fault, prot}, 32'h7);
        walk(VA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
        chk(fault && err_code == 3'b011, "R7 sup write with wp", {28'd0, fault, err_code}, 32'hB);
    endtask

    task automatic t_busy_start;
        mem.delete();
        mem[DIRA] = 32'h0002_0027;
        mem[TBLA] = 32'h0055_5067;
        mem_lat = 3;
        @(negedge clk);
        nacc = 0;
        vaddr = VA; is_write = 1'b0; is_user = 1'b0; paging_on = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        vaddr = 32'h0000_0000; paging_on = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cyc = 0;
        while (!done && r_cyc < 200) begin
            @(negedge clk);
            r_cyc++;
        end
        chk(!fault && phys_addr == 32'h0055_5ABC, "R11 start ignored while busy", phys_addr, 32'h0055_5ABC);
        chk(nacc == 2, "R11 slow memory accesses", 32'(nacc), 32'd2);
        @(negedge clk);
        chk(!done, "R11 done single cycle", {31'd0, done}, 32'd0);
        mem_lat = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pg_off();
        t_small_read();
        t_accessed_wb();
        t_dirty();
        t_big();
        t_not_present();
        t_perm();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule